// File: doc/BRIEF.md
# Inter-Burst Wait and Select-Lead Timer

This block sits between a serial burst controller and the select and clock drivers of a serial peripheral port. When the controller signals that a burst has finished, the block holds off the next burst for a programmable number of wait states. It then raises a ready level. When a start request arrives while ready is high, the block counts a second, programmable lead delay in system clocks. It then issues a single-cycle strobe that tells the select driver to assert the chip select.

The wait states can be counted in one of two time bases, chosen by a source select input. One base is a serial-clock tick that is already synchronous to the system clock. The other is a slow reference clock of about 32.768 kHz, which arrives asynchronously. The reference is brought into the system domain through a two-flop synchroniser, and each of its rising edges counts as one tick. The selection is read live on every cycle, so a change of source part-way through a gap keeps the count already reached.

Top module: `spi_gap_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `ready` and `cs_assert` are both 0.
- R2: A `burst_done` pulse in the idle state with `wait_count` = 0 makes `ready` go high on the next cycle.
- R3: With `wait_count` = N (1 to 32767), `ready` goes high in the cycle after the clock edge that samples the N-th selected tick following the `burst_done` pulse.
- R4: With `src_sel` = 0, the selected tick is `sclk_tick`, sampled high at a clock edge. Activity on `ref_tick_raw` has no effect on the gap.
- R5: With `src_sel` = 1, the selected tick is a rising edge of `ref_tick_raw` after two synchronising flops. A rise that is first sampled at edge k is counted at edge k+2. `sclk_tick` has no effect on the gap.
- R6: A change of `src_sel` during a gap does not reset the count. Ticks from the newly selected source continue the count from where it stands.
- R7: `ready` stays high until `start_req` is sampled high. `start_req` has no effect in any other state.
- R8: With `cs_delay` = D sampled together with `start_req`, `cs_assert` is high in the cycle that comes D+1 edges after that start edge. `ready` and `cs_assert` are never high together.
- R9: `cs_assert` lasts exactly one cycle, and the block then returns to idle. A `burst_done` pulse that arrives outside idle is ignored.
- R10: `wait_count` is captured when `burst_done` is accepted, and `cs_delay` is captured when `start_req` is accepted. Changes to either input after capture do not alter the timing already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_done | input | 1 | One-cycle pulse: previous burst finished |
| start_req | input | 1 | Request to begin the next burst |
| wait_count | input | 15 | Number of wait states in the gap |
| src_sel | input | 1 | Tick source: 0 serial-clock tick, 1 reference clock |
| cs_delay | input | 6 | Select-lead delay in system clocks |
| sclk_tick | input | 1 | Serial-clock tick, synchronous to clk |
| ref_tick_raw | input | 1 | Slow reference clock, asynchronous |
| ready | output | 1 | High while a new burst may be started |
| cs_assert | output | 1 | One-cycle strobe to assert chip select |

## Verification
The properties assume that `burst_done`, `start_req`, `sclk_tick`, `wait_count`, `cs_delay` and `src_sel` are synchronous to `clk`. Only `ref_tick_raw` may change at arbitrary times. They also assume that the controller treats `burst_done` and `start_req` as level samples taken on each edge. The stimulus changes every synchronous input only on the falling clock edge. It toggles the reference input far more slowly than the system clock, so that each rise survives synchronisation. It also deliberately sends pulses into states where they must be ignored.

// File: rtl/gap_pkg.sv
package gap_pkg;

    localparam int GAP_CNT_W  = 15;
    localparam int LEAD_CNT_W = 6;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READY,
        ST_LEAD,
        ST_FIRE
    } gap_state_e;

    typedef struct packed {
        logic load_gap;
        logic dec_gap;
        logic load_lead;
        logic dec_lead;
    } cnt_ctrl_t;

    function automatic logic is_zero_val(input logic [GAP_CNT_W-1:0] v);
        return v == '0;
    endfunction

endpackage

// File: rtl/gap_ref_sync.sv
module gap_ref_sync #(
    parameter int STAGES = gap_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], async_in};
            prev_q  <= chain_q[TOP];
        end
    end

    assign rise = chain_q[TOP] & ~prev_q;
endmodule

// File: rtl/gap_tick_sel.sv
module gap_tick_sel (
    input  logic sel,
    input  logic fast_tick,
    input  logic slow_rise,
    output logic tick
);
    assign tick = sel ? slow_rise : fast_tick;
endmodule

// File: rtl/gap_down_cnt.sv
module gap_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/gap_seq.sv
module gap_seq
    import gap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       burst_done,
    input  logic       start_req,
    input  logic       gap_zero,
    input  logic       lead_zero,
    input  logic       tick,
    input  logic       gap_last,
    input  logic       lead_last,
    output cnt_ctrl_t  ctrl,
    output gap_state_e state
);
    gap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        ctrl    = '0;
        unique case (state_q)
            ST_IDLE: if (burst_done) begin
                ctrl.load_gap = 1'b1;
                state_d = gap_zero ? ST_READY : ST_WAIT;
            end
            ST_WAIT: begin
                ctrl.dec_gap = tick;
                if (tick && gap_last) state_d = ST_READY;
            end
            ST_READY: if (start_req) begin
                ctrl.load_lead = 1'b1;
                state_d = lead_zero ? ST_FIRE : ST_LEAD;
            end
            ST_LEAD: begin
                ctrl.dec_lead = 1'b1;
                if (lead_last) state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer
    import gap_pkg::*;
#(
    parameter int GW = GAP_CNT_W,
    parameter int LW = LEAD_CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_done,
    input  logic          start_req,
    input  logic [GW-1:0] wait_count,
    input  logic          src_sel,
    input  logic [LW-1:0] cs_delay,
    input  logic          sclk_tick,
    input  logic          ref_tick_raw,
    output logic          ready,
    output logic          cs_assert
);
    logic       ref_rise, sel_tick, gap_last, lead_last;
    cnt_ctrl_t  ctrl;
    gap_state_e state_q;

    gap_ref_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .async_in(ref_tick_raw), .rise(ref_rise)
    );

    gap_tick_sel u_sel (
        .sel(src_sel), .fast_tick(sclk_tick), .slow_rise(ref_rise), .tick(sel_tick)
    );

    gap_down_cnt #(.W(GW)) u_gap_cnt (
        .clk(clk), .rst(rst), .load(ctrl.load_gap), .load_val(wait_count),
        .dec(ctrl.dec_gap), .last(gap_last)
    );

    gap_down_cnt #(.W(LW)) u_lead_cnt (
        .clk(clk), .rst(rst), .load(ctrl.load_lead), .load_val(cs_delay),
        .dec(ctrl.dec_lead), .last(lead_last)
    );

    gap_seq u_seq (
        .clk(clk), .rst(rst), .burst_done(burst_done), .start_req(start_req),
        .gap_zero(wait_count == '0), .lead_zero(cs_delay == '0),
        .tick(sel_tick), .gap_last(gap_last), .lead_last(lead_last),
        .ctrl(ctrl), .state(state_q)
    );

    assign ready     = (state_q == ST_READY);
    assign cs_assert = (state_q == ST_FIRE);
endmodule

// File: rtl/spi_gap_timer_chk.sv
module spi_gap_timer_chk
    import gap_pkg::*;
#(
    parameter int GW = GAP_CNT_W,
    parameter int LW = LEAD_CNT_W
) (
    input logic          clk,
    input logic          rst,
    input logic          burst_done,
    input logic          start_req,
    input logic [GW-1:0] wait_count,
    input logic [LW-1:0] cs_delay,
    input logic          ready,
    input logic          cs_assert,
    input gap_state_e    state_q
);
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(ready && cs_assert));

    p_one_shot_r9: assert property (@(posedge clk) disable iff (rst)
        cs_assert |=> !cs_assert);

    p_back_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cs_assert |=> state_q == ST_IDLE);

    p_hold_ready_r7: assert property (@(posedge clk) disable iff (rst)
        ready && !start_req |=> ready);

    p_zero_gap_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE && burst_done && wait_count == '0 |=> ready);

    p_zero_lead_r8: assert property (@(posedge clk) disable iff (rst)
        ready && start_req && cs_delay == '0 |=> cs_assert);

    p_wait_exit_r9: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_WAIT |=> (state_q == ST_WAIT || state_q == ST_READY));
endmodule

bind spi_gap_timer spi_gap_timer_chk #(.GW(GW), .LW(LW)) chk_i (
    .clk(clk), .rst(rst), .burst_done(burst_done), .start_req(start_req),
    .wait_count(wait_count), .cs_delay(cs_delay), .ready(ready),
    .cs_assert(cs_assert), .state_q(state_q)
);

// File: tb/spi_gap_timer_tb.sv
module spi_gap_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        burst_done = 1'b0, start_req = 1'b0, src_sel = 1'b0;
    logic [14:0] wait_count = '0;
    logic [5:0]  cs_delay = '0;
    logic        sclk_tick = 1'b0, ref_tick_raw = 1'b0;
    logic        ready, cs_assert;

    int total = 0, bad = 0;
    bit finished = 0;
    string tag = "R1";

    int sclk_every = 0;   // 0: no ticks, n: one tick every n cycles
    int ref_half   = 0;   // 0: reference held, n: toggles every n cycles

    always #4 clk = ~clk;

    spi_gap_timer dut_i (
        .clk(clk), .rst(rst), .burst_done(burst_done), .start_req(start_req),
        .wait_count(wait_count), .src_sel(src_sel), .cs_delay(cs_delay),
        .sclk_tick(sclk_tick), .ref_tick_raw(ref_tick_raw),
        .ready(ready), .cs_assert(cs_assert)
    );

    // background tick generators, driven away from the active edge
    initial begin
        int sc = 0, rc = 0;
        forever begin
            @(negedge clk);
            sc++; rc++;
            sclk_tick = (sclk_every != 0) && (sc % sclk_every == 0);
            if (ref_half != 0 && rc >= ref_half) begin
                ref_tick_raw = ~ref_tick_raw;
                rc = 0;
            end
        end
    end

    // behavioural reference: phase 0 idle,1 gap,2 ready,3 lead,4 fire
    int m_phase = 0, m_left = 0, m_lead = 0;
    bit seen1 = 0, seen2 = 0, seen3 = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_left = 0; m_lead = 0;
            seen1 = 0; seen2 = 0; seen3 = 0;
        end else begin
            bit t;
            t = src_sel ? (seen2 && !seen3) : sclk_tick;
            if (m_phase == 0) begin
                if (burst_done) begin
                    m_left  = int'(wait_count);
                    m_phase = (m_left == 0) ? 2 : 1;
                end
            end else if (m_phase == 1) begin
                if (t) begin
                    m_left--;
                    if (m_left == 0) m_phase = 2;
                end
            end else if (m_phase == 2) begin
                if (start_req) begin
                    m_lead  = int'(cs_delay);
                    m_phase = (m_lead == 0) ? 4 : 3;
                end
            end else if (m_phase == 3) begin
                m_lead--;
                if (m_lead == 0) m_phase = 4;
            end else begin
                m_phase = 0;
            end
            seen3 = seen2; seen2 = seen1; seen1 = ref_tick_raw;
        end
    end

    task automatic check_now();
        bit er, ec;
        er = (m_phase == 2);
        ec = (m_phase == 4);
        total++;
        if (ready !== er || cs_assert !== ec) begin
            bad++;
            $display("FAIL %s t=%0t ready/cs actual=%b%b expected=%b%b",
                     tag, $time, ready, cs_assert, er, ec);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic pulse_done();
        burst_done = 1'b1; cyc(1); burst_done = 1'b0;
    endtask

    task automatic pulse_start();
        start_req = 1'b1; cyc(1); start_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1"; cyc(3);
        rst = 1'b0;
        cyc(1);

        // R2: zero gap, R8 zero lead
        tag = "R2"; wait_count = 15'd0; pulse_done(); cyc(3);
        tag = "R8"; cs_delay = 6'd0; pulse_start(); cyc(4);

        // R4/R3: serial ticks every 3rd cycle, reference toggling but unselected
        tag = "R4"; src_sel = 1'b0; sclk_every = 3; ref_half = 2;
        wait_count = 15'd5; pulse_done();
        tag = "R10"; wait_count = 15'd1; cyc(4);
        tag = "R9"; pulse_done();
        tag = "R7"; pulse_start();
        tag = "R3"; cyc(20);
        tag = "R7"; cyc(5);
        tag = "R10"; cs_delay = 6'd4; pulse_start(); cs_delay = 6'd0; cyc(8);

        // R5: reference selected, serial ticks every cycle but unselected
        tag = "R5"; src_sel = 1'b1; sclk_every = 1; ref_half = 6;
        wait_count = 15'd3; pulse_done(); cyc(60);
        cs_delay = 6'd1; pulse_start(); cyc(5);

        // R6: switch source mid-gap
        tag = "R6"; src_sel = 1'b0; sclk_every = 4; ref_half = 5;
        wait_count = 15'd6; pulse_done(); cyc(10);
        src_sel = 1'b1; cyc(60);
        cs_delay = 6'd2; pulse_start(); cyc(6);

        // R3 boundary: full gap, longest lead
        tag = "R3"; src_sel = 1'b0; sclk_every = 1; ref_half = 0;
        wait_count = 15'h7FFF; pulse_done(); cyc(32770);
        tag = "R8"; cs_delay = 6'd63; pulse_start(); cyc(70);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule